// File: doc/BRIEF.md
# Paged Memory Management Unit

This block sits between a CPU with a 16-bit address bus and a 1 MB RAM space. It splits the CPU address space into eight 8 KB logical pages. Address bits [15:13] pick the page. A programmable lookup table turns each page into a 7-bit physical page number, which becomes bits [19:13] of a 20-bit RAM address. The table has sixteen entries arranged as two banks of eight, and a control bit chooses which bank is used for translation. Each entry also carries a write-protect flag.

On every CPU bus cycle the block produces the translated address. It also asserts one chip select for boot ROM, RAM or I/O, and a RAM write strobe that honours write protection. While enabled, the boot ROM overlays the top page. A 16-byte I/O window near the top of the address space always decodes as I/O. A fixed-top-of-RAM mode pins the top 512 bytes to physical page 7 and is switched on by a control write that would otherwise re-enable the ROM. Writing the step bit of the control register starts a counter that raises a one-clock NMI pulse a fixed number of bus cycles later, which allows single-instruction stepping.

Software reaches the block through two write-only byte registers inside the I/O window. One is the control register and the other is the table data register.

Top module: `page_mmu`

## Requirements
- R1: With the enable bit set (control bit 5), a RAM access to logical page p takes physical address bits [19:13] from table entry {bank, p}. Bits [12:0] pass through unchanged.
- R2: Control bit 6 selects the bank: 0 uses entries 0-7 and 1 uses entries 8-15.
- R3: Reset clears the ROM-disable, bank, enable and fixed-top bits. With the enable bit clear, page p maps to physical page p. Table entries keep their contents across reset. An idle cycle (bus_valid low) asserts no select and no write strobe.
- R4: While ROM-disable (control bit 7) is 0, any access in 0xE000-0xFFFF outside the I/O window asserts rom_cs, and ram_cs stays low, whatever the mapping. At most one of rom_cs and ram_cs is high.
- R5: Addresses 0xFFD0-0xFFDF always assert io_cs.
- R6: A read in the I/O window asserts no ROM and no RAM select. A write there also selects RAM at the translated address, but only when the top page is not overlaid by ROM.
- R7: A RAM write to a page whose entry has bit 7 (write protect) set asserts ram_cs but not ram_we. Otherwise a RAM write asserts ram_we.
- R8: When ROM-disable and enable are both 1, a control write with bit 4 = 0, bit 7 = 0 and bit 5 = 1 keeps ROM-disable at 1 and sets fixed-top mode.
- R9: In fixed-top mode, addresses 0xFE00-0xFFFF translate to physical page 7 with no write protection, whatever page 7 maps to.
- R10: A control write with bit 4 = 0 and bit 5 = 0 clears fixed-top mode.
- R11: A control write with bit 4 = 1 leaves ROM-disable, bank, enable, fixed-top mode and the entry select unchanged.
- R12: The last control write with bit 4 = 1 is followed by step_nmi going high for exactly one clock. This happens after NMI_DELAY further cycles with bus_valid high; cycles with bus_valid low are not counted.
- R13: A write to the data register (0xFFDF) loads the entry named by control bits [3:0]. Data bit 7 is the write protect and bits [6:0] are the physical page. The control register is at 0xFFDE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | A CPU bus cycle is in progress this clock |
| bus_we | input | 1 | Bus cycle is a write |
| bus_addr | input | 16 | CPU logical address |
| bus_wdata | input | 8 | CPU write data |
| phys_addr | output | 20 | Translated RAM address |
| rom_cs | output | 1 | Boot ROM select |
| ram_cs | output | 1 | RAM select |
| io_cs | output | 1 | I/O window select |
| ram_we | output | 1 | RAM write strobe after write protection |
| step_nmi | output | 1 | One-clock single-step NMI pulse |

## Verification
The bench builds the block with NMI_DELAY set to 6 and keeps the default register addresses and I/O window. The short delay lets the step pulse, together with a run of idle cycles that must not count toward it, be seen within a handful of accesses. It also leaves time for a retrigger-free measurement of the pulse width. With the default window, the ROM overlay, fixed-top pinning and I/O-window double writes can all be exercised at the addresses software would actually use.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  // Control register bit positions (software-visible layout)
  localparam int CTL_ROMDIS = 7;
  localparam int CTL_BANK   = 6;
  localparam int CTL_EN     = 5;
  localparam int CTL_STEP   = 4;
  localparam int SEL_W      = 4;
  // Data register layout
  localparam int DAT_WP     = 7;
  localparam int PPAGE_W    = 7;
  localparam int LPAGE_W    = 3;
  localparam int OFFS_W     = 13;

  typedef struct packed {
    logic             romdis;
    logic             bank;
    logic             en;
    logic             frt;
    logic [SEL_W-1:0] sel;
  } mmu_ctl_t;

  typedef struct packed {
    logic               wp;
    logic [PPAGE_W-1:0] ppage;
  } map_entry_t;
endpackage

// File: rtl/mmu_ctl_reg.sv
module mmu_ctl_reg
  import mmu_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  logic [7:0] wdata,
  output mmu_ctl_t ctl,
  output logic     step_start
);
  mmu_ctl_t ctl_q, ctl_n;
  logic     frt_seq;

  always_comb begin
    ctl_n      = ctl_q;
    step_start = 1'b0;
    frt_seq    = ctl_q.romdis && ctl_q.en && !wdata[CTL_ROMDIS] && wdata[CTL_EN];
    if (wr_en) begin
      if (wdata[CTL_STEP]) begin
        step_start = 1'b1;
      end else begin
        ctl_n.romdis = frt_seq ? 1'b1 : wdata[CTL_ROMDIS];
        ctl_n.bank   = wdata[CTL_BANK];
        ctl_n.en     = wdata[CTL_EN];
        ctl_n.sel    = wdata[SEL_W-1:0];
        if (!wdata[CTL_EN])
          ctl_n.frt = 1'b0;
        else if (frt_seq)
          ctl_n.frt = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_n;
  end

  assign ctl = ctl_q;
endmodule

// File: rtl/mmu_map_table.sv
module mmu_map_table
  import mmu_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  map_entry_t       wr_entry,
  input  logic [IDX_W-1:0] rd_idx,
  output map_entry_t       rd_entry
);
  map_entry_t ent_q [ENTRIES];

  // Entries hold no reset: contents survive a reset by design
  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic ld;
    assign ld = wr_en && (wr_idx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (ld) ent_q[i] <= wr_entry;
    end
  end

  assign rd_entry = ent_q[rd_idx];
endmodule

// File: rtl/mmu_step_timer.sv
module mmu_step_timer #(
  parameter int DELAY = 20,
  localparam int CNT_W = $clog2(DELAY + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic fire
);
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             fire_q, fire_n;

  always_comb begin
    fire_n = tick && (cnt_q == CNT_W'(1));
    cnt_n  = cnt_q;
    if (start)
      cnt_n = CNT_W'(DELAY);
    else if (tick && cnt_q != '0)
      cnt_n = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      fire_q <= fire_n;
    end
  end

  assign fire = fire_q;
endmodule

// File: rtl/mmu_addr_decode.sv
module mmu_addr_decode
  import mmu_pkg::*;
#(
  parameter logic [15:0] IO_BASE = 16'hFFD0,
  localparam int PADDR_W = PPAGE_W + OFFS_W
) (
  input  logic                   bus_valid,
  input  logic                   bus_we,
  input  logic [15:0]            bus_addr,
  input  mmu_ctl_t               ctl,
  input  map_entry_t             entry,
  output logic [LPAGE_W:0]       rd_idx,
  output logic [PADDR_W-1:0]     phys_addr,
  output logic                   rom_cs,
  output logic                   ram_cs,
  output logic                   io_cs,
  output logic                   ram_we
);
  logic [LPAGE_W-1:0] lpage;
  logic               io_hit, rom_hit, frt_hit, wp;
  logic [PPAGE_W-1:0] ppage;

  always_comb begin
    lpage   = bus_addr[15:OFFS_W];
    rd_idx  = {ctl.bank, lpage};
    io_hit  = bus_addr[15:4] == IO_BASE[15:4];
    rom_hit = !ctl.romdis && (lpage == '1);
    frt_hit = ctl.frt && (bus_addr[15:9] == '1);
    if (frt_hit) begin
      ppage = PPAGE_W'(7);
      wp    = 1'b0;
    end else if (ctl.en) begin
      ppage = entry.ppage;
      wp    = entry.wp;
    end else begin
      ppage = PPAGE_W'(lpage);
      wp    = 1'b0;
    end
    phys_addr = {ppage, bus_addr[OFFS_W-1:0]};
    io_cs  = bus_valid && io_hit;
    rom_cs = bus_valid && rom_hit && !io_hit;
    ram_cs = bus_valid && !rom_hit && (!io_hit || bus_we);
    ram_we = ram_cs && bus_we && !wp;
  end
endmodule

// File: rtl/page_mmu.sv
module page_mmu
  import mmu_pkg::*;
#(
  parameter logic [15:0] IO_BASE   = 16'hFFD0,
  parameter logic [15:0] CTRL_ADDR = 16'hFFDE,
  parameter logic [15:0] DATA_ADDR = 16'hFFDF,
  parameter int          NMI_DELAY = 20,
  localparam int         ENTRIES   = 2 << LPAGE_W,
  localparam int         PADDR_W   = PPAGE_W + OFFS_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_valid,
  input  logic               bus_we,
  input  logic [15:0]        bus_addr,
  input  logic [7:0]         bus_wdata,
  output logic [PADDR_W-1:0] phys_addr,
  output logic               rom_cs,
  output logic               ram_cs,
  output logic               io_cs,
  output logic               ram_we,
  output logic               step_nmi
);
  logic       ctl_wr, dat_wr, step_start;
  mmu_ctl_t   ctl_q;
  map_entry_t rd_entry;
  logic [LPAGE_W:0] rd_idx;

  assign ctl_wr = bus_valid && bus_we && (bus_addr == CTRL_ADDR);
  assign dat_wr = bus_valid && bus_we && (bus_addr == DATA_ADDR);

  mmu_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(ctl_wr), .wdata(bus_wdata),
    .ctl(ctl_q), .step_start(step_start)
  );

  mmu_map_table #(.ENTRIES(ENTRIES)) u_tbl (
    .clk(clk), .wr_en(dat_wr), .wr_idx(ctl_q.sel), .wr_entry(map_entry_t'(bus_wdata)),
    .rd_idx(rd_idx), .rd_entry(rd_entry)
  );

  mmu_addr_decode #(.IO_BASE(IO_BASE)) u_dec (
    .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
    .ctl(ctl_q), .entry(rd_entry), .rd_idx(rd_idx), .phys_addr(phys_addr),
    .rom_cs(rom_cs), .ram_cs(ram_cs), .io_cs(io_cs), .ram_we(ram_we)
  );

  mmu_step_timer #(.DELAY(NMI_DELAY)) u_step (
    .clk(clk), .rst_n(rst_n), .start(step_start), .tick(bus_valid), .fire(step_nmi)
  );
endmodule

// File: rtl/page_mmu_chk.sv
module page_mmu_chk #(
  parameter logic [15:0] CTRL_ADDR = 16'hFFDE,
  parameter int          NMI_DELAY = 20
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_valid,
  input logic        bus_we,
  input logic [15:0] bus_addr,
  input logic [7:0]  bus_wdata,
  input logic        rom_cs,
  input logic        ram_cs,
  input logic        io_cs,
  input logic        ram_we,
  input logic        step_nmi,
  input logic        romdis,
  input logic        bank,
  input logic        en,
  input logic        frt
);
  logic cw;
  assign cw = bus_valid && bus_we && (bus_addr == CTRL_ADDR);

  // R4
  rom_ram_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_cs, ram_cs}));
  // R6
  io_no_rom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_cs |-> !rom_cs);
  // R7
  we_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_cs && bus_we));
  // R11
  step_keeps_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cw && bus_wdata[4]) |=> $stable({romdis, bank, en, frt}));
  // R10
  frt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cw && !bus_wdata[4] && !bus_wdata[5]) |=> !frt);
  // R8
  frt_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frt) |-> $past(cw && romdis && en));
  // R12
  nmi_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_nmi && NMI_DELAY > 1) |=> !step_nmi);
endmodule

bind page_mmu page_mmu_chk #(.CTRL_ADDR(CTRL_ADDR), .NMI_DELAY(NMI_DELAY)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rom_cs(rom_cs), .ram_cs(ram_cs),
  .io_cs(io_cs), .ram_we(ram_we), .step_nmi(step_nmi), .romdis(ctl_q.romdis),
  .bank(ctl_q.bank), .en(ctl_q.en), .frt(ctl_q.frt)
);

// File: tb/page_mmu_test.sv
module page_mmu_test;
  localparam int DLY = 6;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [19:0] phys_addr;
  logic rom_cs, ram_cs, io_cs, ram_we, step_nmi;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  page_mmu #(.NMI_DELAY(DLY)) uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .phys_addr(phys_addr),
    .rom_cs(rom_cs), .ram_cs(ram_cs), .io_cs(io_cs), .ram_we(ram_we),
    .step_nmi(step_nmi)
  );

  typedef struct {
    string      tag;
    logic       cmp_pa;
    logic [19:0] pa;
    logic [4:0] sig; // rom, ram, io, we, nmi
  } item_t;
  item_t sb[$];

  // reference state, from the requirements
  logic m_romdis, m_bank, m_en, m_frt, m_nmi;
  logic [3:0] m_sel;
  logic [7:0] m_tbl [16];
  int m_cnt;

  task automatic model_reset();
    m_romdis = 0; m_bank = 0; m_en = 0; m_frt = 0; m_sel = 0; m_nmi = 0; m_cnt = 0;
  endtask

  task automatic cyc(input string tag, input logic v, input logic [15:0] a,
                     input logic w, input logic [7:0] d);
    item_t it;
    logic io, rom, frt_pg, wp, ram;
    logic [6:0] pp;
    @(negedge clk);
    bus_valid = v; bus_addr = a; bus_we = w; bus_wdata = d;
    io     = a[15:4] == 12'hFFD;
    rom    = !m_romdis && a[15:13] == 3'd7;
    frt_pg = m_frt && a[15:9] == 7'h7F;
    if (frt_pg) begin pp = 7; wp = 0; end
    else if (m_en) begin pp = m_tbl[{m_bank, a[15:13]}][6:0]; wp = m_tbl[{m_bank, a[15:13]}][7]; end
    else begin pp = {4'd0, a[15:13]}; wp = 0; end
    ram = v && !rom && (!io || w);
    it.tag = tag; it.cmp_pa = ram; it.pa = {pp, a[12:0]};
    it.sig = {v && rom && !io, ram, v && io, ram && w && !wp, m_nmi};
    sb.push_back(it);
    // effect of the coming clock edge
    m_nmi = v && (m_cnt == 1);
    if (v && w && a == 16'hFFDE && d[4]) m_cnt = DLY;
    else if (v && m_cnt != 0) m_cnt = m_cnt - 1;
    if (v && w && a == 16'hFFDE && !d[4]) begin
      logic seq;
      seq = m_romdis && m_en && !d[7] && d[5];
      m_romdis = seq ? 1'b1 : d[7];
      m_bank = d[6]; m_en = d[5]; m_sel = d[3:0];
      if (!d[5]) m_frt = 0; else if (seq) m_frt = 1;
    end
    if (v && w && a == 16'hFFDF) m_tbl[m_sel] = d;
  endtask

  task automatic rd(input string t, input logic [15:0] a); cyc(t, 1, a, 0, 8'h00); endtask
  task automatic wr(input string t, input logic [15:0] a, input logic [7:0] d); cyc(t, 1, a, 1, d); endtask
  task automatic idle(input string t); cyc(t, 0, 16'h0000, 0, 8'h00); endtask

  // monitor: pops one expectation per cycle, samples mid low phase
  initial begin
    forever begin
      @(negedge clk); #5;
      if (sb.size() > 0) begin
        item_t e;
        e = sb.pop_front();
        n_run++;
        if ({rom_cs, ram_cs, io_cs, ram_we, step_nmi} !== e.sig ||
            (e.cmp_pa && phys_addr !== e.pa)) begin
          n_fail++;
          $display("FAIL %s: got sel=%b pa=%h expected sel=%b pa=%h",
                   e.tag, {rom_cs, ram_cs, io_cs, ram_we, step_nmi}, phys_addr, e.sig, e.pa);
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    idle("R3 idle after reset");
    rd("R3 identity map", 16'h2345);
    rd("R4 rom overlay at reset", 16'hE100);
    rd("R5 io read", 16'hFFD1);
    wr("R6 io write under rom", 16'hFFD5, 8'h11);
    // R13: program every entry through select then data
    for (int i = 0; i < 16; i++) begin
      wr("R13 select", 16'hFFDE, 8'(i));
      wr("R13 load", 16'hFFDF, {(i == 2 || i == 7 || i == 10) ? 1'b1 : 1'b0, 7'(8'h10 + i * 3)});
    end
    wr("R1 enable", 16'hFFDE, 8'h20);
    rd("R1 bank0 page2", 16'h4567);
    wr("R7 protected write", 16'h4000, 8'h55);
    wr("R1 unprotected write", 16'h2000, 8'h55);
    rd("R4 rom wins over map", 16'hE000);
    wr("R2 bank1", 16'hFFDE, 8'h60);
    rd("R2 bank1 page1", 16'h2ABC);
    wr("R4 rom off", 16'hFFDE, 8'hA0);
    rd("R4 ram at top page", 16'hE010);
    wr("R6 io write with ram", 16'hFFD3, 8'h22);
    rd("R6 io read with ram", 16'hFFD3);
    wr("R8 fixed-top sequence", 16'hFFDE, 8'h20);
    rd("R8 rom stays off", 16'hE010);
    rd("R9 fixed top low", 16'hFE10);
    rd("R9 fixed top high", 16'hFFF0);
    rd("R9 below fixed top", 16'hFC00);
    wr("R9 fixed top ignores protect", 16'hFE00, 8'h33);
    wr("R7 page7 protected", 16'hFC00, 8'h33);
    // R11 and R12
    wr("R12 trigger", 16'hFFDE, 8'h10);
    rd("R11 state kept", 16'hFE10);
    rd("R11 bank kept", 16'h4000);
    idle("R12 idle not counted");
    idle("R12 idle not counted");
    for (int i = 0; i < DLY + 2; i++) rd("R12 step pulse", 16'h1000);
    wr("R10 clear", 16'hFFDE, 8'h00);
    rd("R10 rom back", 16'hFE10);
    wr("R10 reenable", 16'hFFDE, 8'hA0);
    rd("R10 fixed top gone", 16'hFE10);
    wr("R13 select 5", 16'hFFDE, 8'h25);
    wr("R13 load 5", 16'hFFDF, 8'h33);
    rd("R13 entry5", 16'hA123);
    idle("R3 settle");
    @(negedge clk); #6;
    rst_n = 1'b0; model_reset();
    @(negedge clk); rst_n = 1'b1;
    rd("R3 reset clears rom disable", 16'hE100);
    wr("R3 enable after reset", 16'hFFDE, 8'h20);
    rd("R3 table kept", 16'hA123);
    idle("end");
    @(negedge clk); #8;
    n_run++;
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL R1 queue: got %0d expected 0", sb.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule